// File: doc/BRIEF.md
# PHY Analog Trim Load Sequencer

This block brings an on-chip Ethernet PHY to its calibrated state after reset without software. On a start pulse it samples a 32-bit configuration word (normally fed from fuses) and pulls three analog trim fields out of it. When every field is zero the block only waits for the PHY's own self-calibration: it reads a status bit in the PHY's extended register space a bounded number of times, with a gap before each read. When any field is non-zero it merges each field into the low bits of its own extended register by read-modify-write. It then sets a commit bit in a handshake register and polls that register's acknowledge bit a bounded number of times.

The PHY's extended registers are reached indirectly. The extended address is written to MII register 30, and the data then moves through MII register 29. The block drives a simple request/response port. A request stays on the port until a one-cycle response arrives, and the serial management bus that carries it lies outside this block. All waiting intervals are parameters counted in clock cycles. A settling interval ends every run, after which `done` rises. `timeout_err` reports a poll budget that ran out. `ack_warn` reports an acknowledge bit that was already set before the commit.

States: `S_IDLE`, `S_SELF_WAIT` (gap, then to `S_SELF_READ`), `S_SELF_READ` (to `S_SETTLE` when the ready bit is seen or the budget runs out, else back to `S_SELF_WAIT`), `S_TRIM_READ` (to `S_TRIM_WRITE`), `S_TRIM_WRITE` (to the next `S_TRIM_READ`, or after the third field to `S_HS_READ`), `S_HS_READ` (to `S_HS_WRITE`), `S_HS_WRITE` (to `S_ACK_WAIT`), `S_ACK_WAIT` (gap, then to `S_ACK_READ`), `S_ACK_READ` (to `S_SETTLE` on acknowledge or an empty budget, else back to `S_ACK_WAIT`), and `S_SETTLE` (to `S_IDLE` with `done` set). `S_IDLE` goes to `S_SELF_WAIT` when all fields are zero and to `S_TRIM_READ` otherwise.

Top module: `phy_trim_loader`

## Requirements
- R1: After reset, `busy`, `done`, `timeout_err`, `ack_warn` and `mdio_req_valid` are all 0.
- R2: Only three fields of `cfg_word` count: field A = bits [29:25], field B = bits [24:22], field C = bits [21:16]. The other bits have no effect. If any field is non-zero the programming path runs, otherwise the self-calibration path runs.
- R3: Every extended access is two requests. The first writes the 16-bit extended address to MII register 30. The second reads or writes MII register 29. A request keeps valid, register, write flag and data unchanged until `mdio_rsp_valid` arrives.
- R4: On the programming path, extended registers 0x3050, 0x3051 and 0x3052 are each read and written back exactly once, in that order. Field A replaces the low 5 bits of 0x3050, field B the low 3 bits of 0x3051 and field C the low 6 bits of 0x3052. All other bits keep their read value.
- R5: Next, 0x3053 is read. `ack_warn` becomes the value of its bit 1. The value read is written back with bit 0 set.
- R6: After that write, the block waits ACK_GAP cycles before each read of 0x3053 and stops at the first read with bit 1 set. After ACK_TRIES reads without it, `timeout_err` is set.
- R7: On the self-calibration path, no register 29 write is issued. Extended register 0x3057 is read, with at least SELF_GAP cycles before each read, until bit 0 reads 1 or SELF_TRIES reads have been made. In the second case `timeout_err` is set.
- R8: SETTLE cycles after the last response of a run, `done` goes to 1 and `busy` goes to 0. `done`, `timeout_err` and `ack_warn` hold until the next accepted start clears them.
- R9: A start pulse while `busy` is 1 is ignored. The running sequence and its result are unchanged.
- R10: Every request carries the PHY address sampled from `phy_addr` at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, accepted only when idle |
| cfg_word | input | 32 | Configuration word holding the trim fields |
| phy_addr | input | 5 | PHY address used for the run |
| mdio_req_valid | output | 1 | Management request pending |
| mdio_req_write | output | 1 | 1 = write request, 0 = read request |
| mdio_req_phy | output | 5 | PHY address of the request |
| mdio_req_reg | output | 5 | MII register number of the request |
| mdio_req_wdata | output | 16 | Write data of the request |
| mdio_rsp_valid | input | 1 | One-cycle completion of the pending request |
| mdio_rsp_rdata | input | 16 | Read data, valid with `mdio_rsp_valid` |
| busy | output | 1 | Sequence running |
| done | output | 1 | Run finished, held until the next start |
| timeout_err | output | 1 | Poll budget ran out in the last run |
| ack_warn | output | 1 | Acknowledge bit was already set before the commit |

## Verification
Two functions can fall on the same register read. The first read of 0x3053 both raises the early-acknowledge warning and leaves the acknowledge bit set, so the first poll that follows must end the run with no timeout. The bench provokes this by preloading bit 1 of its PHY model's 0x3053. It then requires `ack_warn` = 1, exactly one poll and `timeout_err` = 0. A second collision is a start pulse that arrives while a run is active. The bench judges it by the final register contents, which must still match the first configuration word, and by a single set of trim writes.

// File: rtl/trim_pkg.sv
package trim_pkg;

    // MII register numbers used for indirect extended access
    localparam logic [4:0] MII_XDATA = 5'd29;
    localparam logic [4:0] MII_XADDR = 5'd30;

    // Extended register addresses
    localparam logic [15:0] XR_FIELD_A = 16'h3050;
    localparam logic [15:0] XR_HSHAKE  = 16'h3053;
    localparam logic [15:0] XR_SELFCAL = 16'h3057;

    // Field positions inside the configuration word
    localparam int FA_LSB = 25;
    localparam int FB_LSB = 22;
    localparam int FC_LSB = 16;
    localparam int FA_W   = 5;
    localparam int FB_W   = 3;
    localparam int FC_W   = 6;
    localparam logic [31:0] FIELD_MASK = 32'h3FFF_0000;

    typedef struct packed {
        logic [FA_W-1:0] fa;
        logic [FB_W-1:0] fb;
        logic [FC_W-1:0] fc;
    } trim_fields_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SELF_WAIT,
        S_SELF_READ,
        S_TRIM_READ,
        S_TRIM_WRITE,
        S_HS_READ,
        S_HS_WRITE,
        S_ACK_WAIT,
        S_ACK_READ,
        S_SETTLE
    } seq_state_t;

    typedef enum logic [1:0] {
        E_IDLE,
        E_ADDR,
        E_DATA
    } acc_state_t;

    function automatic trim_fields_t unpack_fields(input logic [31:0] word);
        logic [31:0]  w;
        trim_fields_t f;
        w    = word & FIELD_MASK;
        f.fa = w[FA_LSB +: FA_W];
        f.fb = w[FB_LSB +: FB_W];
        f.fc = w[FC_LSB +: FC_W];
        return f;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/trim_field_merge.sv
module trim_field_merge
    import trim_pkg::*;
(
    input  logic [1:0]   sel,
    input  trim_fields_t fields,
    input  logic [15:0]  rd_val,
    output logic [15:0]  merged
);
    localparam int NUM_F = 3;

    logic [15:0] keep_mask [NUM_F];
    logic [15:0] ins_val   [NUM_F];

    // Per-field mask and insert value, one generate arm per field width
    for (genvar g = 0; g < NUM_F; g++) begin : g_fld
        localparam int WID = (g == 0) ? FA_W : ((g == 1) ? FB_W : FC_W);
        assign keep_mask[g] = ~((16'd1 << WID) - 16'd1);
        if (g == 0) begin : g_a
            assign ins_val[g] = 16'(fields.fa);
        end else if (g == 1) begin : g_b
            assign ins_val[g] = 16'(fields.fb);
        end else begin : g_c
            assign ins_val[g] = 16'(fields.fc);
        end
    end

    always_comb begin
        unique case (sel)
            2'd0:    merged = (rd_val & keep_mask[0]) | ins_val[0];
            2'd1:    merged = (rd_val & keep_mask[1]) | ins_val[1];
            2'd2:    merged = (rd_val & keep_mask[2]) | ins_val[2];
            default: merged = rd_val;
        endcase
    end
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && (cnt_q == limit - 1'b1);

    // R6/R7/R8: a window never overshoots its limit
    assert_window_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run && (limit != '0) |-> cnt_q < limit);
endmodule

// File: rtl/ext_reg_access.sv
module ext_reg_access
    import trim_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_req,
    input  logic        acc_write,
    input  logic [15:0] acc_xaddr,
    input  logic [15:0] acc_wdata,
    input  logic [4:0]  acc_phy,
    output logic        acc_done,
    output logic [15:0] acc_rdata,
    output logic        mdio_req_valid,
    output logic        mdio_req_write,
    output logic [4:0]  mdio_req_phy,
    output logic [4:0]  mdio_req_reg,
    output logic [15:0] mdio_req_wdata,
    input  logic        mdio_rsp_valid,
    input  logic [15:0] mdio_rsp_rdata
);
    acc_state_t st_q, st_d;
    logic        wr_q;
    logic [15:0] xaddr_q;
    logic [15:0] wdata_q;
    logic [4:0]  phy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= E_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            E_IDLE: if (acc_req)        st_d = E_ADDR;
            E_ADDR: if (mdio_rsp_valid) st_d = E_DATA;
            E_DATA: if (mdio_rsp_valid) st_d = E_IDLE;
            default:                    st_d = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            xaddr_q <= '0;
            wdata_q <= '0;
            phy_q   <= '0;
        end else if (st_q == E_IDLE && acc_req) begin
            wr_q    <= acc_write;
            xaddr_q <= acc_xaddr;
            wdata_q <= acc_wdata;
            phy_q   <= acc_phy;
        end
    end

    always_comb begin
        mdio_req_valid = (st_q != E_IDLE);
        mdio_req_phy   = phy_q;
        mdio_req_write = (st_q == E_ADDR) ? 1'b1 : wr_q;
        mdio_req_reg   = (st_q == E_ADDR) ? MII_XADDR : MII_XDATA;
        mdio_req_wdata = (st_q == E_ADDR) ? xaddr_q : wdata_q;
        acc_done       = (st_q == E_DATA) && mdio_rsp_valid;
        acc_rdata      = mdio_rsp_rdata;
    end

    // R3: a pending request holds still until its response
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req_valid && !mdio_rsp_valid |=> mdio_req_valid
            && $stable(mdio_req_reg) && $stable(mdio_req_write)
            && $stable(mdio_req_wdata) && $stable(mdio_req_phy));

    // R3: each access opens with the address write to register 30
    assert_addr_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_req_valid) |-> mdio_req_write && (mdio_req_reg == MII_XADDR));
endmodule

// File: rtl/phy_trim_loader.sv
module phy_trim_loader
    import trim_pkg::*;
#(
    parameter int SELF_GAP   = 25_000_000,
    parameter int SELF_TRIES = 3,
    parameter int ACK_GAP    = 12_000,
    parameter int ACK_TRIES  = 3000,
    parameter int SETTLE     = 500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] cfg_word,
    input  logic [4:0]  phy_addr,
    output logic        mdio_req_valid,
    output logic        mdio_req_write,
    output logic [4:0]  mdio_req_phy,
    output logic [4:0]  mdio_req_reg,
    output logic [15:0] mdio_req_wdata,
    input  logic        mdio_rsp_valid,
    input  logic [15:0] mdio_rsp_rdata,
    output logic        busy,
    output logic        done,
    output logic        timeout_err,
    output logic        ack_warn
);
    localparam int TW  = $clog2(max3(SELF_GAP, ACK_GAP, SETTLE) + 1);
    localparam int NW  = $clog2(((SELF_TRIES > ACK_TRIES) ? SELF_TRIES : ACK_TRIES) + 1);
    localparam logic [NW-1:0] SELF_LAST = NW'(SELF_TRIES - 1);
    localparam logic [NW-1:0] ACK_LAST  = NW'(ACK_TRIES - 1);
    localparam logic [1:0]    LAST_FLD  = 2'd2;

    seq_state_t   state_q, state_d;
    trim_fields_t fields_q, fields_in;
    logic [4:0]   phy_q;
    logic [1:0]   idx_q;
    logic [NW-1:0] tries_q;
    logic [15:0]  wbuf_q;
    logic         done_q, err_q, warn_q;

    logic         acc_req, acc_write, acc_done;
    logic [15:0]  acc_xaddr, acc_rdata, merged;
    logic         tmr_run, tmr_exp;
    logic [TW-1:0] tmr_limit;
    logic         accept, all_zero;

    assign fields_in = unpack_fields(cfg_word);
    assign all_zero  = (fields_in == '0);
    assign accept    = start && (state_q == S_IDLE);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:
                if (accept) state_d = all_zero ? S_SELF_WAIT : S_TRIM_READ;
            S_SELF_WAIT:
                if (tmr_exp) state_d = S_SELF_READ;
            S_SELF_READ:
                if (acc_done)
                    state_d = (acc_rdata[0] || tries_q == SELF_LAST) ? S_SETTLE : S_SELF_WAIT;
            S_TRIM_READ:
                if (acc_done) state_d = S_TRIM_WRITE;
            S_TRIM_WRITE:
                if (acc_done) state_d = (idx_q == LAST_FLD) ? S_HS_READ : S_TRIM_READ;
            S_HS_READ:
                if (acc_done) state_d = S_HS_WRITE;
            S_HS_WRITE:
                if (acc_done) state_d = S_ACK_WAIT;
            S_ACK_WAIT:
                if (tmr_exp) state_d = S_ACK_READ;
            S_ACK_READ:
                if (acc_done)
                    state_d = (acc_rdata[1] || tries_q == ACK_LAST) ? S_SETTLE : S_ACK_WAIT;
            S_SETTLE:
                if (tmr_exp) state_d = S_IDLE;
            default:
                state_d = S_IDLE;
        endcase
    end

    // ---------------- access and timer control ----------------
    always_comb begin
        acc_req   = 1'b0;
        acc_write = 1'b0;
        acc_xaddr = XR_HSHAKE;
        tmr_run   = 1'b0;
        tmr_limit = TW'(SETTLE);
        unique case (state_q)
            S_SELF_WAIT: begin tmr_run = 1'b1; tmr_limit = TW'(SELF_GAP); end
            S_ACK_WAIT:  begin tmr_run = 1'b1; tmr_limit = TW'(ACK_GAP);  end
            S_SETTLE:    begin tmr_run = 1'b1; tmr_limit = TW'(SETTLE);   end
            S_SELF_READ: begin acc_req = 1'b1; acc_xaddr = XR_SELFCAL; end
            S_TRIM_READ: begin acc_req = 1'b1; acc_xaddr = XR_FIELD_A + 16'(idx_q); end
            S_TRIM_WRITE: begin
                acc_req = 1'b1; acc_write = 1'b1; acc_xaddr = XR_FIELD_A + 16'(idx_q);
            end
            S_HS_READ:   begin acc_req = 1'b1; end
            S_HS_WRITE:  begin acc_req = 1'b1; acc_write = 1'b1; end
            S_ACK_READ:  begin acc_req = 1'b1; end
            default: ;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields_q <= '0;
            phy_q    <= '0;
            idx_q    <= '0;
            tries_q  <= '0;
            wbuf_q   <= '0;
        end else begin
            if (accept) begin
                fields_q <= fields_in;
                phy_q    <= phy_addr;
                idx_q    <= '0;
                tries_q  <= '0;
            end
            if (acc_done) begin
                unique case (state_q)
                    S_TRIM_READ:  wbuf_q  <= merged;
                    S_TRIM_WRITE: idx_q   <= idx_q + 1'b1;
                    S_HS_READ:    wbuf_q  <= acc_rdata | 16'h0001;
                    S_SELF_READ,
                    S_ACK_READ:   tries_q <= tries_q + 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- output flags ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            warn_q <= 1'b0;
        end else begin
            if (accept) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
                warn_q <= 1'b0;
            end
            if (acc_done && state_q == S_HS_READ)
                warn_q <= acc_rdata[1];
            if (acc_done && state_q == S_SELF_READ && !acc_rdata[0] && tries_q == SELF_LAST)
                err_q <= 1'b1;
            if (acc_done && state_q == S_ACK_READ && !acc_rdata[1] && tries_q == ACK_LAST)
                err_q <= 1'b1;
            if (state_q == S_SETTLE && tmr_exp)
                done_q <= 1'b1;
        end
    end

    assign busy        = (state_q != S_IDLE);
    assign done        = done_q;
    assign timeout_err = err_q;
    assign ack_warn    = warn_q;

    // ---------------- sub-blocks ----------------
    trim_field_merge u_merge (
        .sel    (idx_q),
        .fields (fields_q),
        .rd_val (acc_rdata),
        .merged (merged)
    );

    wait_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .limit  (tmr_limit),
        .expire (tmr_exp)
    );

    ext_reg_access u_acc (
        .clk            (clk),
        .rst_n          (rst_n),
        .acc_req        (acc_req),
        .acc_write      (acc_write),
        .acc_xaddr      (acc_xaddr),
        .acc_wdata      (wbuf_q),
        .acc_phy        (phy_q),
        .acc_done       (acc_done),
        .acc_rdata      (acc_rdata),
        .mdio_req_valid (mdio_req_valid),
        .mdio_req_write (mdio_req_write),
        .mdio_req_phy   (mdio_req_phy),
        .mdio_req_reg   (mdio_req_reg),
        .mdio_req_wdata (mdio_req_wdata),
        .mdio_rsp_valid (mdio_rsp_valid),
        .mdio_rsp_rdata (mdio_rsp_rdata)
    );

    // ---------------- assertions ----------------
    // R9: a start during a run changes none of the sampled run inputs
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(fields_q) && $stable(phy_q));

    // R8: done is only shown once the sequencer is idle
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: requests always carry the sampled PHY address
    assert_phy_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req_valid && busy |-> mdio_req_phy == phy_q);

    // R5: the early-acknowledge warning belongs to the programming path
    assert_warn_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_warn |-> fields_q != '0);

    // R6/R7: poll counter stays inside its budget
    assert_tries_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACK_WAIT || state_q == S_ACK_READ) |-> tries_q < NW'(ACK_TRIES));

    // R7: no register 29 write while on the self-calibration path
    assert_self_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SELF_READ) && mdio_req_valid && (mdio_req_reg == MII_XDATA)
            |-> !mdio_req_write);
endmodule

// File: tb/phy_trim_loader_bench.sv
module phy_trim_loader_bench;
    localparam int SELF_GAP   = 20;
    localparam int SELF_TRIES = 3;
    localparam int ACK_GAP    = 12;
    localparam int ACK_TRIES  = 5;
    localparam int SETTLE     = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [4:0]  phy_addr = '0;
    logic        mdio_req_valid, mdio_req_write;
    logic [4:0]  mdio_req_phy, mdio_req_reg;
    logic [15:0] mdio_req_wdata;
    logic        mdio_rsp_valid = 1'b0;
    logic [15:0] mdio_rsp_rdata = '0;
    logic        busy, done, timeout_err, ack_warn;

    always #5 clk = ~clk;

    phy_trim_loader #(
        .SELF_GAP(SELF_GAP), .SELF_TRIES(SELF_TRIES), .ACK_GAP(ACK_GAP),
        .ACK_TRIES(ACK_TRIES), .SETTLE(SETTLE)
    ) u_phy_trim_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word),
        .phy_addr(phy_addr), .mdio_req_valid(mdio_req_valid),
        .mdio_req_write(mdio_req_write), .mdio_req_phy(mdio_req_phy),
        .mdio_req_reg(mdio_req_reg), .mdio_req_wdata(mdio_req_wdata),
        .mdio_rsp_valid(mdio_rsp_valid), .mdio_rsp_rdata(mdio_rsp_rdata),
        .busy(busy), .done(done), .timeout_err(timeout_err), .ack_warn(ack_warn)
    );

    int n_chk = 0;
    int n_bad = 0;

    // ---------------- PHY model ----------------
    logic [15:0] regs [0:7];
    logic [15:0] xaddr = '0;
    int   ack_after = 1, self_after = 1, lat = 0;
    int   trim_writes = 0, data_writes = 0, ack_polls = 0, self_reads = 0;
    int   proto_err = 0, armed = 0, exp_phy = 0;
    int   cyc = 0, last_self = 0, min_gap = 1000000, last_rsp = 0;
    logic m_busy = 1'b0;
    int   m_cnt = 0;
    logic m_wr = 1'b0;
    logic [4:0]  m_reg = '0;
    logic [15:0] m_wd = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (m_busy) begin
            if (m_cnt == 0) begin
                m_busy         <= 1'b0;
                mdio_rsp_valid <= 1'b1;
                last_rsp       <= cyc;
                if (m_reg == 5'd30 && m_wr) begin
                    xaddr <= m_wd;
                end else if (m_reg == 5'd29 && xaddr >= 16'h3050 && xaddr <= 16'h3057) begin
                    if (m_wr) begin
                        regs[xaddr[2:0]] <= m_wd;
                        data_writes      <= data_writes + 1;
                        if (xaddr <= 16'h3052) trim_writes <= trim_writes + 1;
                        if (xaddr == 16'h3053 && m_wd[0]) armed <= 1;
                    end else if (xaddr == 16'h3053 && armed != 0) begin
                        ack_polls <= ack_polls + 1;
                        if (ack_after != 0 && ack_polls + 1 >= ack_after) begin
                            regs[3][1]     <= 1'b1;
                            mdio_rsp_rdata <= regs[3] | 16'h0002;
                        end else begin
                            mdio_rsp_rdata <= regs[3];
                        end
                    end else if (xaddr == 16'h3057) begin
                        self_reads     <= self_reads + 1;
                        mdio_rsp_rdata <= {15'd0, (self_after != 0 && self_reads + 1 >= self_after)};
                    end else begin
                        mdio_rsp_rdata <= regs[xaddr[2:0]];
                    end
                end else begin
                    proto_err <= proto_err + 1;
                end
            end else begin
                m_cnt <= m_cnt - 1;
            end
        end else if (mdio_rsp_valid) begin
            mdio_rsp_valid <= 1'b0;
        end else if (mdio_req_valid) begin
            m_busy <= 1'b1;
            m_cnt  <= lat;
            m_wr   <= mdio_req_write;
            m_reg  <= mdio_req_reg;
            m_wd   <= mdio_req_wdata;
            if (int'(mdio_req_phy) != exp_phy) proto_err <= proto_err + 1;
            if (mdio_req_reg == 5'd29 && !mdio_req_write && xaddr == 16'h3057) begin
                if (cyc - last_self < min_gap) min_gap <= cyc - last_self;
                last_self <= cyc;
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [31:0] w, input logic [4:0] p);
        @(negedge clk);
        cfg_word = w;
        phy_addr = p;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    int done_cyc = 0;
    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; done_cyc = cyc; break; end
        end
    endtask

    task automatic run_case(input logic [31:0] w, input logic [4:0] p,
                            input logic [15:0] pat, input bit warn_init,
                            input int acka, input int selfa, input int l,
                            input bit poke);
        logic [15:0] init [0:7];
        logic [4:0] fa; logic [2:0] fb; logic [5:0] fc;
        bit ok, zero, exp_err;
        int exp_polls;
        @(negedge clk);
        for (int i = 0; i < 8; i++) init[i] = pat ^ (16'h1111 * 16'(i));
        init[3] = (init[3] & 16'hFFFC) | (warn_init ? 16'h0002 : 16'h0000);
        for (int i = 0; i < 8; i++) regs[i] = init[i];
        ack_after = acka; self_after = selfa; lat = l; exp_phy = int'(p);
        trim_writes = 0; data_writes = 0; ack_polls = 0; self_reads = 0;
        proto_err = 0; armed = 0; min_gap = 1000000; last_self = cyc;
        fa = w[29:25]; fb = w[24:22]; fc = w[21:16];
        zero = (fa == 0) && (fb == 0) && (fc == 0);
        pulse_start(w, p);
        last_self = cyc;
        if (poke) begin
            repeat (30) @(negedge clk);
            cfg_word = ~w; phy_addr = ~p; start = 1'b1;          // R9 stimulus
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R9 still busy after ignored start", int'(busy), 1);
        end
        wait_done(ok);
        chk(ok, "R8 done reached", int'(ok), 1);
        chk(busy == 1'b0, "R8 busy low at done", int'(busy), 0);
        chk(done_cyc - last_rsp >= SETTLE && done_cyc - last_rsp <= SETTLE + 4,
            "R8 settle interval", done_cyc - last_rsp, SETTLE);
        chk(proto_err == 0, "R3 R10 request protocol and PHY address", proto_err, 0);
        if (!zero) begin
            chk(regs[0] == ((init[0] & 16'hFFE0) | 16'(fa)), "R4 merge 0x3050", int'(regs[0]),
                int'((init[0] & 16'hFFE0) | 16'(fa)));
            chk(regs[1] == ((init[1] & 16'hFFF8) | 16'(fb)), "R4 merge 0x3051", int'(regs[1]),
                int'((init[1] & 16'hFFF8) | 16'(fb)));
            chk(regs[2] == ((init[2] & 16'hFFC0) | 16'(fc)), "R4 merge 0x3052", int'(regs[2]),
                int'((init[2] & 16'hFFC0) | 16'(fc)));
            chk(trim_writes == 3, "R4 one write per trim register", trim_writes, 3);
            chk(regs[3][0] == 1'b1, "R5 commit bit written", int'(regs[3][0]), 1);
            chk(ack_warn == warn_init, "R5 early acknowledge warning", int'(ack_warn), int'(warn_init));
            if (warn_init) exp_polls = 1;
            else if (acka == 0 || acka > ACK_TRIES) exp_polls = ACK_TRIES;
            else exp_polls = acka;
            exp_err = !warn_init && (acka == 0 || acka > ACK_TRIES);
            chk(ack_polls == exp_polls, "R6 acknowledge poll count", ack_polls, exp_polls);
            chk(timeout_err == exp_err, "R6 acknowledge timeout flag", int'(timeout_err), int'(exp_err));
        end else begin
            exp_polls = (selfa == 0 || selfa > SELF_TRIES) ? SELF_TRIES : selfa;
            exp_err   = (selfa == 0 || selfa > SELF_TRIES);
            chk(data_writes == 0, "R7 no data writes on self path", data_writes, 0);
            chk(self_reads == exp_polls, "R7 self poll count", self_reads, exp_polls);
            chk(timeout_err == exp_err, "R7 self timeout flag", int'(timeout_err), int'(exp_err));
            chk(min_gap >= SELF_GAP, "R7 gap before each self poll", min_gap, SELF_GAP);
            chk(ack_warn == 1'b0, "R7 no warning on self path", int'(ack_warn), 0);
            for (int i = 0; i < 4; i++)
                chk(regs[i] == init[i], "R2 registers untouched on self path", int'(regs[i]), int'(init[i]));
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    logic [4:0] fav [0:2];
    logic [2:0] fbv [0:2];
    logic [5:0] fcv [0:2];
    initial begin
        int k;
        fav[0] = 5'd0; fav[1] = 5'd1;  fav[2] = 5'd31;
        fbv[0] = 3'd0; fbv[1] = 3'd5;  fbv[2] = 3'd7;
        fcv[0] = 6'd0; fcv[1] = 6'h2A; fcv[2] = 6'd63;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0, "R1 reset busy/done", int'({busy, done}), 0);
        chk(timeout_err == 0 && ack_warn == 0, "R1 reset flags", int'({timeout_err, ack_warn}), 0);
        chk(mdio_req_valid == 0, "R1 reset request idle", int'(mdio_req_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R4 R5 R6: sweep over field combinations with noise in unused bits
        k = 0;
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
                for (int c = 0; c < 3; c++) begin
                    logic [31:0] w;
                    if (a == 0 && b == 0 && c == 0) continue;
                    w = {2'b10, fav[a], fbv[b], fcv[c], 16'hA5C3 ^ 16'(k * 7)};
                    run_case(w, 5'(k + 1), (k % 2 == 0) ? 16'hFFFF : 16'h5A00,
                             (k % 5) == 4, 1 + (k % 3), 1, k % 3, 1'b0);
                    k++;
                end

        // R6: acknowledge never arrives, budget exhausted
        run_case({2'b00, 5'd3, 3'd2, 6'd1, 16'h0000}, 5'd9, 16'h1234, 1'b0, 0, 1, 1, 1'b0);
        // R6: acknowledge on the very last allowed poll
        run_case({2'b00, 5'd0, 3'd0, 6'd9, 16'hFFFF}, 5'd4, 16'h0F0F, 1'b0, ACK_TRIES, 1, 0, 1'b0);

        // R7 R2: all fields zero, noise elsewhere; ready after 1..3 reads, and never
        for (int s = 0; s <= SELF_TRIES; s++)
            run_case(32'hC000_FFFF, 5'(20 + s), 16'hBEEF, 1'b0, 1, s, s % 3, 1'b0);

        // R9: start during a run is ignored
        run_case({2'b01, 5'd17, 3'd3, 6'd33, 16'h0001}, 5'd12, 16'h8001, 1'b0, 2, 1, 1, 1'b1);

        // R8: done holds while idle, then clears on the next accepted start
        repeat (20) @(negedge clk);
        chk(done == 1'b1, "R8 done held while idle", int'(done), 1);
        pulse_start(32'h0000_0000, 5'd1);
        chk(done == 1'b0 && busy == 1'b1, "R8 done cleared by new start", int'({done, busy}), 1);
        begin
            bit ok;
            self_after = 1; exp_phy = 1;
            wait_done(ok);
            chk(ok, "R8 done after restart", int'(ok), 1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule